// File: doc/BRIEF.md
# Data-Ready Interrupt Flag Controller

This block produces an active-low "new results ready" flag for a host that reads a converter's result registers over a serial link. The converter signals the block with a one-cycle strobe when a conversion, or a whole sequence of conversions, has finished and its results are stored. The host's result reads arrive as a one-cycle read strobe. The on-chip conversion timer arrives as a one-cycle strobe that starts a fresh conversion. The flag drops when results land. It rises again when the host reads them or when the timer starts the next conversion, whichever comes first.

A read that clears the flag also arms an internal read-seen latch. While that latch is set, further reads do nothing. The host re-arms it by writing an all-zero word to the latch-clear register at address 0x81. A mode bit (bit 13 of the control register at address 0x03) decides what drives the shared interrupt pin. When the bit is 0 the pin carries the flag. When it is 1 the pin carries an alarm input that comes from elsewhere. Each register write is a one-cycle transaction on a simple write port.

Top module: `dready_irq_tracker`

## Requirements
- R1: After reset the flag output is high, the read-seen latch is clear, the mode bit is 0 and the interrupt pin is high.
- R2: A completion strobe with no timer strobe in the same cycle drives the flag low on the next clock edge.
- R3: A read strobe that arrives while the flag is low, the latch is clear and no completion or timer strobe is present drives the flag high on the next edge and sets the latch.
- R4: A timer strobe drives the flag high on the next edge whether or not the results were read. It takes priority over a completion strobe in the same cycle.
- R5: While the latch is set, a read strobe leaves the flag unchanged.
- R6: A write of 0x0000 to address 0x81 clears the latch. A nonzero write to 0x81, or a zero write to any other address, leaves the latch as it was.
- R7: A write to address 0x03 loads bit 13 of the write data into the mode bit. With mode 0 the interrupt pin equals the flag; with mode 1 it equals the alarm input. Writes to other addresses leave the mode bit unchanged.
- R8: With no strobe present the flag holds its value. A read while the flag is high changes nothing and does not set the latch.
- R9: A completion strobe and a read strobe in the same cycle leave the flag low and do not set the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_done | input | 1 | One-cycle strobe: conversion results written |
| result_rd | input | 1 | One-cycle strobe: host read of the result registers |
| timer_start | input | 1 | One-cycle strobe: timer expired, new conversion started |
| wr_en | input | 1 | Host register write valid |
| wr_addr | input | 8 | Host register write address |
| wr_data | input | 16 | Host register write data |
| alarm_n | input | 1 | Active-low alarm routed to the pin when mode is 1 |
| drdy_n | output | 1 | Active-low data-ready flag |
| irq_n | output | 1 | Shared interrupt pin |

## Verification
Every strobe and write lands in a register on the clock edge where it is sampled. So the flag, the latch and the mode bit show their new values one cycle after the stimulus. The pin follows the alarm input combinationally in the same cycle. The bench drives each stimulus just after a falling edge. After the following rising edge it queues the expected flag and pin values. A monitor compares them at the next falling edge, one cycle after the stimulus, while the alarm input is still held at the value the expectation used. Latch effects show up through the flag response to a later read.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int unsigned DR_ADDR_W    = 8;
  localparam int unsigned DR_DATA_W    = 16;
  localparam int unsigned DR_MODE_BIT  = 13;
  localparam logic [7:0]  DR_CLR_ADDR  = 8'h81;
  localparam logic [7:0]  DR_CTRL_ADDR = 8'h03;

  typedef enum logic {
    PIN_SRC_FLAG  = 1'b0,
    PIN_SRC_ALARM = 1'b1
  } pin_src_e;

  typedef struct packed {
    logic done;
    logic rd;
    logic tmr;
  } strobe_t;
endpackage

// File: rtl/dr_rst_sync.sv
module dr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST:0], 1'b1} >> 0;
    chain_d[0] = 1'b1;
    for (int i = 1; i <= int'(LAST); i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/dr_host_regs.sv
module dr_host_regs #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MODE_BIT  = 13,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h81,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output dr_pkg::pin_src_e  mode_q,
  output logic              latch_clr
);
  localparam logic [DATA_W-1:0] CLR_WORD = '0;

  logic             ctrl_hit;
  logic             mode_en;
  dr_pkg::pin_src_e mode_d;

  assign ctrl_hit  = wr_en && (wr_addr == CTRL_ADDR);
  assign latch_clr = wr_en && (wr_addr == CLR_ADDR) && (wr_data == CLR_WORD);

  always_comb begin
    mode_en = ctrl_hit;
    mode_d  = mode_q;
    if (mode_en) begin
      mode_d = wr_data[MODE_BIT] ? dr_pkg::PIN_SRC_ALARM : dr_pkg::PIN_SRC_FLAG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= dr_pkg::PIN_SRC_FLAG;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/dr_read_latch.sv
module dr_read_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_accept,
  input  logic clr,
  output logic latch_q
);
  logic latch_d;
  logic latch_en;

  always_comb begin
    latch_en = clr || rd_accept;
    latch_d  = latch_q;
    if (clr) begin
      latch_d = 1'b0;
    end else if (rd_accept) begin
      latch_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/dr_flag_ctl.sv
module dr_flag_ctl (
  input  logic            clk,
  input  logic            rst_n,
  input  dr_pkg::strobe_t stb,
  input  logic            latch_q,
  output logic            flag_n_q,
  output logic            rd_accept
);
  logic flag_n_d;
  logic flag_en;

  assign rd_accept = stb.rd && !flag_n_q && !latch_q && !stb.done && !stb.tmr;

  always_comb begin
    flag_en  = stb.tmr || stb.done || rd_accept;
    flag_n_d = flag_n_q;
    if (stb.tmr) begin
      flag_n_d = 1'b1;
    end else if (stb.done) begin
      flag_n_d = 1'b0;
    end else if (rd_accept) begin
      flag_n_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n_q <= 1'b1;
    end else if (flag_en) begin
      flag_n_q <= flag_n_d;
    end
  end
endmodule

// File: rtl/dready_irq_tracker.sv
module dready_irq_tracker #(
  parameter int unsigned ADDR_W      = dr_pkg::DR_ADDR_W,
  parameter int unsigned DATA_W      = dr_pkg::DR_DATA_W,
  parameter int unsigned MODE_BIT    = dr_pkg::DR_MODE_BIT,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = dr_pkg::DR_CLR_ADDR,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = dr_pkg::DR_CTRL_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic              result_rd,
  input  logic              timer_start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alarm_n,
  output logic              drdy_n,
  output logic              irq_n
);
  logic             rst_q;
  logic             latch_q;
  logic             latch_clr;
  logic             rd_accept;
  dr_pkg::pin_src_e mode_q;
  dr_pkg::strobe_t  stb;

  assign stb = '{done: conv_done, rd: result_rd, tmr: timer_start};

  dr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_q)
  );

  dr_host_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MODE_BIT (MODE_BIT),
    .CLR_ADDR (CLR_ADDR),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode_q   (mode_q),
    .latch_clr(latch_clr)
  );

  dr_flag_ctl u_flag (
    .clk      (clk),
    .rst_n    (rst_q),
    .stb      (stb),
    .latch_q  (latch_q),
    .flag_n_q (drdy_n),
    .rd_accept(rd_accept)
  );

  dr_read_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_q),
    .rd_accept(rd_accept),
    .clr      (latch_clr),
    .latch_q  (latch_q)
  );

  always_comb begin
    unique case (mode_q)
      dr_pkg::PIN_SRC_ALARM: irq_n = alarm_n;
      default:               irq_n = drdy_n;
    endcase
  end
endmodule

// File: rtl/dr_tracker_chk.sv
module dr_tracker_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MODE_BIT = 13,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h81,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h03
) (
  input logic              clk,
  input logic              rst_q,
  input logic              conv_done,
  input logic              result_rd,
  input logic              timer_start,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              drdy_n,
  input logic              latch_q,
  input logic              mode_q
);
  p_done_lowers_r2: assert property (@(posedge clk) disable iff (!rst_q)
    conv_done && !timer_start |=> !drdy_n);

  p_read_raises_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !drdy_n && result_rd && !latch_q && !conv_done && !timer_start |=> drdy_n && latch_q);

  p_timer_raises_r4: assert property (@(posedge clk) disable iff (!rst_q)
    timer_start |=> drdy_n);

  p_read_blocked_r5: assert property (@(posedge clk) disable iff (!rst_q)
    result_rd && latch_q && !conv_done && !timer_start |=> $stable(drdy_n));

  p_clear_latch_r6: assert property (@(posedge clk) disable iff (!rst_q)
    wr_en && (wr_addr == CLR_ADDR) && (wr_data == '0) |=> !latch_q);

  p_mode_load_r7: assert property (@(posedge clk) disable iff (!rst_q)
    wr_en && (wr_addr == CTRL_ADDR) |=> mode_q == $past(wr_data[MODE_BIT]));

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !conv_done && !timer_start && !result_rd |=> $stable(drdy_n));
endmodule

bind dready_irq_tracker dr_tracker_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .MODE_BIT (MODE_BIT),
  .CLR_ADDR (CLR_ADDR),
  .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .conv_done  (conv_done),
  .result_rd  (result_rd),
  .timer_start(timer_start),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .drdy_n     (drdy_n),
  .latch_q    (latch_q),
  .mode_q     (mode_q)
);

// File: tb/test_dready_irq_tracker.sv
module test_dready_irq_tracker;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        conv_done;
  logic        result_rd;
  logic        timer_start;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic        alarm_n;
  logic        drdy_n;
  logic        irq_n;

  typedef struct {
    logic  flag;
    logic  pin;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done_run = 0;

  logic m_flag;
  logic m_latch;
  logic m_mode;

  dready_irq_tracker i_dready_irq_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .result_rd  (result_rd),
    .timer_start(timer_start),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .alarm_n    (alarm_n),
    .drdy_n     (drdy_n),
    .irq_n      (irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic step(input logic d, input logic r, input logic t,
                      input logic we, input logic [7:0] a, input logic [15:0] wd,
                      input logic al, input string tag);
    logic acc;
    @(negedge clk);
    #1;
    conv_done = d; result_rd = r; timer_start = t;
    wr_en = we; wr_addr = a; wr_data = wd; alarm_n = al;
    acc = r && !m_flag && !m_latch && !d && !t;
    if (t)        m_flag = 1'b1;
    else if (d)   m_flag = 1'b0;
    else if (acc) m_flag = 1'b1;
    if (we && a == 8'h81 && wd == 16'h0000) m_latch = 1'b0;
    else if (acc)                           m_latch = 1'b1;
    if (we && a == 8'h03) m_mode = wd[13];
    @(posedge clk);
    exp_q.push_back('{flag: m_flag, pin: (m_mode ? al : m_flag), tag: tag});
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (drdy_n !== e.flag || irq_n !== e.pin) begin
        errors++;
        $display("FAIL %s: drdy_n=%b irq_n=%b expected drdy_n=%b irq_n=%b",
                 e.tag, drdy_n, irq_n, e.flag, e.pin);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; conv_done = 0; result_rd = 0; timer_start = 0;
    wr_en = 0; wr_addr = '0; wr_data = '0; alarm_n = 1'b1;
    m_flag = 1'b1; m_latch = 1'b0; m_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (drdy_n !== 1'b1 || irq_n !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: drdy_n=%b irq_n=%b expected 1 1", drdy_n, irq_n);
    end
    step(0,0,0, 0,8'h00,16'h0000, 1, "R8 idle hold high");
    step(0,1,0, 0,8'h00,16'h0000, 1, "R8 read while high");
    step(1,0,0, 0,8'h00,16'h0000, 1, "R2 done lowers");
    step(0,0,0, 0,8'h00,16'h0000, 1, "R8 hold low");
    step(0,1,0, 0,8'h00,16'h0000, 1, "R3 read raises (R1 latch clear)");
    step(1,0,0, 0,8'h00,16'h0000, 1, "R2 done lowers again");
    step(0,1,0, 0,8'h00,16'h0000, 1, "R5 read blocked");
    step(0,0,0, 1,8'h81,16'h0001, 1, "R6 nonzero clear write");
    step(0,1,0, 0,8'h00,16'h0000, 1, "R6 latch kept by nonzero");
    step(0,0,0, 1,8'h80,16'h0000, 1, "R6 zero write other addr");
    step(0,1,0, 0,8'h00,16'h0000, 1, "R6 latch kept by other addr");
    step(0,0,0, 1,8'h81,16'h0000, 1, "R6 clear write");
    step(0,1,0, 0,8'h00,16'h0000, 1, "R6 read after clear raises");
    step(0,0,0, 1,8'h81,16'h0000, 1, "R6 clear again");
    step(1,0,0, 0,8'h00,16'h0000, 1, "R2 done before timer");
    step(0,0,1, 0,8'h00,16'h0000, 1, "R4 timer raises unread");
    step(1,0,1, 0,8'h00,16'h0000, 1, "R4 timer beats done");
    step(1,1,0, 0,8'h00,16'h0000, 1, "R9 done and read together");
    step(0,1,0, 0,8'h00,16'h0000, 1, "R9 latch untouched read raises");
    step(0,0,0, 1,8'h81,16'h0000, 1, "R6 clear for mode test");
    step(0,0,0, 1,8'h03,16'h2000, 0, "R7 mode alarm low");
    step(0,0,0, 0,8'h00,16'h0000, 1, "R7 alarm high");
    step(1,0,0, 0,8'h00,16'h0000, 1, "R7 flag low pin alarm");
    step(0,0,0, 1,8'h04,16'h0000, 1, "R7 other addr keeps mode");
    step(0,0,0, 1,8'h03,16'hDFFF, 1, "R7 mode back to flag");
    step(0,0,0, 0,8'h00,16'h0000, 1, "R7 pin follows flag");
    repeat (2) @(posedge clk);
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule